// File: doc/BRIEF.md
# Register-Programmed NCO Frequency Core

This block is a numerically controlled oscillator whose phase step is assembled from programmable frequency words. A host loads bytes over an 8-bit parallel port addressed by a 4-bit register number and qualified by a write strobe. Every byte lands in a staging copy of its register. The datapath only sees the new values once an update pulse copies the entire staging set into the active set in a single clock.

Each clock the 32-bit phase accumulator adds a tuning sum built from three terms. The center word is always included. The offset word is added while the `ofs_en` input is high. The serial-path word is added while its control bit is set. A second control bit picks one of two accumulator modes. In `ACC_INTEGRATE` the accumulator adds the sum to its previous value. In `ACC_RELOAD` it takes the sum alone each clock. The mode follows the active feedback bit, so it switches between these two modes on the edge of any update that changes that bit.

The top 12 phase bits address a quarter-wave sine table that is mirrored into a full signed 16-bit wave. That wave is rounded half-up to a 14-bit two's-complement sample for a downstream converter. Three register stages separate the accumulator from the output. Multi-tone frequency-shift keying is done by rewriting the center word and pulsing update for each tone.

Top module: `nco_tuned_core`

## Requirements
- R1: A write strobe stores `wr_data` into one staging byte. Addresses 0–3 hold the center word, 4–7 the offset word and 8–11 the serial-path word, with the least significant byte at the lowest address of each group. Address 12 is control: bit 0 enables the serial path and bit 1 enables accumulator feedback. Writes to addresses 13–15 have no effect.
- R2: Staged bytes do not change the output until `update` is high at a clock edge. That edge copies all staging registers, as they stood before the edge, into the active registers.
- R3: With `ofs_en` low the offset word is left out of the tuning sum. With it high the offset word is added. The input acts on the same edge it is sampled.
- R4: With control bit 0 clear the serial word is left out of the tuning sum, but its stored value is kept. Setting the bit again later restores its contribution without any rewrite.
- R5: With control bit 1 clear the accumulator loads the tuning sum each clock and does not add its previous value.
- R6: With control bit 1 set the accumulator adds the tuning sum every clock, modulo 2^32.
- R7: For a phase p, let quadrant q = p[31:30] and index i = p[29:20], and let j = 1023−i when q is odd and j = i otherwise. The amplitude is ±round(32767·sin(π/2·(j+0.5)/1024)), negative when q ≥ 2.
- R8: The 16-bit amplitude a is converted to the 14-bit output floor((a+2)/4), clamped at +8191.
- R9: The output sample reflects the accumulator value from exactly three clocks earlier.
- R10: Reset is synchronous and active low, and it acts only at a rising clock edge. It clears the accumulator, all frequency words and the output, and sets control to feedback on, serial off.
- R11: The center word may be rewritten and updated on back-to-back cycles. Each update takes effect on its own edge, with no tone lost.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_en | input | 1 | Byte write strobe |
| wr_addr | input | 4 | Register byte address |
| wr_data | input | 8 | Byte to store |
| update | input | 1 | Copies staging registers to active registers |
| ofs_en | input | 1 | Adds the offset word to the tuning sum |
| sample_out | output | 14 | Rounded signed sine sample |

## Verification
The oscillator is first run with only a center word in integrating mode. This exposes step-size, wrap and table-symmetry errors across all four quadrants. Next, offset and serial words are switched in and out while the stored values stay untouched, which separates a wrong gate from a lost register value. Reload mode with fixed phases then pins the table ends, the saturation at +8191, the most negative code and the exact three-clock latency. A burst of one-cycle center rewrites, writes to unused addresses and a mid-run reset check staging, ignored writes and the edge-only nature of reset.

// File: rtl/nco_pkg.sv
package nco_pkg;
    localparam int BYTE_W     = 8;
    localparam int WORD_W     = 32;
    localparam int ADDR_W     = 4;
    localparam int LUT_ADDR_W = 12;
    localparam int AMP_W      = 16;
    localparam int OUT_W      = 14;
    localparam int NUM_FREQ   = 3;

    // Positions of the frequency words in the register bank
    localparam int FREQ_CENTER = 0;
    localparam int FREQ_OFFSET = 1;
    localparam int FREQ_SERIAL = 2;

    typedef enum logic {
        ACC_INTEGRATE,
        ACC_RELOAD
    } acc_mode_e;

    typedef enum logic [1:0] {
        TGT_NONE,
        TGT_FREQ,
        TGT_CTRL
    } wr_target_e;

    // bit 1: feedback enable, bit 0: serial path enable
    typedef struct packed {
        logic fb_en;
        logic ser_en;
    } ctrl_t;

    localparam ctrl_t CTRL_RESET = '{fb_en: 1'b1, ser_en: 1'b0};
endpackage

// File: rtl/nco_regbank.sv
module nco_regbank
    import nco_pkg::*;
#(
    parameter int AW    = ADDR_W,
    parameter int BW    = BYTE_W,
    parameter int WW    = WORD_W,
    parameter int NFREQ = NUM_FREQ
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      wr_en,
    input  logic [AW-1:0]             wr_addr,
    input  logic [BW-1:0]             wr_data,
    input  logic                      update,
    output logic [NFREQ-1:0][WW-1:0]  freq_stg,
    output logic [NFREQ-1:0][WW-1:0]  freq_act,
    output ctrl_t                     ctrl_act
);
    localparam int BPW    = WW / BW;
    localparam int SEL_W  = $clog2(BPW);
    localparam int CTRL_A = NFREQ * BPW;

    wr_target_e           tgt;
    logic [AW-SEL_W-1:0]  word_sel;
    logic [SEL_W-1:0]     byte_sel;
    ctrl_t                ctrl_stg;

    always_comb begin
        word_sel = wr_addr[AW-1:SEL_W];
        byte_sel = wr_addr[SEL_W-1:0];
        if (!wr_en)
            tgt = TGT_NONE;
        else if (int'(wr_addr) < CTRL_A)
            tgt = TGT_FREQ;
        else if (int'(wr_addr) == CTRL_A)
            tgt = TGT_CTRL;
        else
            tgt = TGT_NONE;
    end

    // Staging side: one byte per strobe
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            freq_stg <= '0;
            ctrl_stg <= CTRL_RESET;
        end else begin
            unique case (tgt)
                TGT_FREQ: freq_stg[word_sel][byte_sel*BW +: BW] <= wr_data;
                TGT_CTRL: ctrl_stg <= ctrl_t'(wr_data[1:0]);
                default:  ;
            endcase
        end
    end

    // Active side: whole set copied on update
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            freq_act <= '0;
            ctrl_act <= CTRL_RESET;
        end else if (update) begin
            freq_act <= freq_stg;
            ctrl_act <= ctrl_stg;
        end
    end
endmodule

// File: rtl/nco_phase_acc.sv
module nco_phase_acc
    import nco_pkg::*;
#(
    parameter int WW    = WORD_W,
    parameter int NFREQ = NUM_FREQ
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic [NFREQ-1:0][WW-1:0] freq_act,
    input  ctrl_t                    ctrl_act,
    input  logic                     ofs_en,
    output logic [WW-1:0]            tune,
    output logic [WW-1:0]            phase
);
    acc_mode_e mode;

    always_comb begin
        tune = freq_act[FREQ_CENTER];
        if (ofs_en)
            tune = tune + freq_act[FREQ_OFFSET];
        if (ctrl_act.ser_en)
            tune = tune + freq_act[FREQ_SERIAL];
        mode = ctrl_act.fb_en ? ACC_INTEGRATE : ACC_RELOAD;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase <= '0;
        end else begin
            unique case (mode)
                ACC_INTEGRATE: phase <= phase + tune;
                ACC_RELOAD:    phase <= tune;
            endcase
        end
    end
endmodule

// File: rtl/nco_sine_lut.sv
module nco_sine_lut
    import nco_pkg::*;
#(
    parameter int PW = WORD_W,
    parameter int LW = LUT_ADDR_W,
    parameter int AW = AMP_W
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [PW-1:0]        phase,
    output logic signed [AW-1:0] amp
);
    localparam int  QTR_W     = LW - 2;
    localparam int  QTR_DEPTH = 1 << QTR_W;
    localparam real HALF_PI   = 3.14159265358979323846 / 2.0;
    localparam real AMP_PEAK  = real'((1 << (AW - 1)) - 1);

    logic [AW-1:0]    quarter [QTR_DEPTH];
    logic [1:0]       s1_quad;
    logic [QTR_W-1:0] s1_idx;
    logic [QTR_W-1:0] idx_m;
    logic [AW-1:0]    mag;

    initial begin
        for (int i = 0; i < QTR_DEPTH; i++) begin
            quarter[i] = AW'($rtoi(AMP_PEAK *
                         $sin(HALF_PI * (real'(i) + 0.5) / real'(QTR_DEPTH)) + 0.5));
        end
    end

    // Stage 1: capture quadrant and table index
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s1_quad <= '0;
            s1_idx  <= '0;
        end else begin
            s1_quad <= phase[PW-1 -: 2];
            s1_idx  <= phase[PW-3 -: QTR_W];
        end
    end

    always_comb begin
        idx_m = s1_quad[0] ? ~s1_idx : s1_idx;
        mag   = quarter[idx_m];
    end

    // Stage 2: mirrored and signed amplitude
    always_ff @(posedge clk) begin
        if (!rst_n)
            amp <= '0;
        else if (s1_quad[1])
            amp <= -$signed(mag);
        else
            amp <= $signed(mag);
    end
endmodule

// File: rtl/nco_round.sv
module nco_round
    import nco_pkg::*;
#(
    parameter int AW = AMP_W,
    parameter int OW = OUT_W
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic signed [AW-1:0] amp,
    output logic signed [OW-1:0] sample
);
    localparam int DROP = AW - OW;

    logic signed [OW-1:0] nxt;

    generate
        if (DROP == 0) begin : g_pass
            always_comb nxt = amp;
        end else begin : g_round
            localparam int HALF = 1 << (DROP - 1);
            logic signed [AW:0] biased;
            logic signed [OW:0] rounded;
            always_comb begin
                biased  = {amp[AW-1], amp} + (AW+1)'(HALF);
                rounded = biased[AW:DROP];
                if (rounded[OW] != rounded[OW-1])
                    nxt = {1'b0, {(OW-1){1'b1}}};
                else
                    nxt = rounded[OW-1:0];
            end
        end
    endgenerate

    // Stage 3: registered output sample
    always_ff @(posedge clk) begin
        if (!rst_n)
            sample <= '0;
        else
            sample <= nxt;
    end
endmodule

// File: rtl/nco_tuned_core.sv
module nco_tuned_core
    import nco_pkg::*;
(
    input  logic                clk,
    input  logic                rst_n,
    input  logic                wr_en,
    input  logic [ADDR_W-1:0]   wr_addr,
    input  logic [BYTE_W-1:0]   wr_data,
    input  logic                update,
    input  logic                ofs_en,
    output logic [OUT_W-1:0]    sample_out
);
    logic [NUM_FREQ-1:0][WORD_W-1:0] freq_stg;
    logic [NUM_FREQ-1:0][WORD_W-1:0] freq_act;
    ctrl_t                           ctrl_act;
    logic [WORD_W-1:0]               tune;
    logic [WORD_W-1:0]               phase;
    logic signed [AMP_W-1:0]         amp;
    logic signed [OUT_W-1:0]         sample_s;

    nco_regbank u_regs (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (wr_en),
        .wr_addr  (wr_addr),
        .wr_data  (wr_data),
        .update   (update),
        .freq_stg (freq_stg),
        .freq_act (freq_act),
        .ctrl_act (ctrl_act)
    );

    nco_phase_acc u_acc (
        .clk      (clk),
        .rst_n    (rst_n),
        .freq_act (freq_act),
        .ctrl_act (ctrl_act),
        .ofs_en   (ofs_en),
        .tune     (tune),
        .phase    (phase)
    );

    nco_sine_lut u_lut (
        .clk   (clk),
        .rst_n (rst_n),
        .phase (phase),
        .amp   (amp)
    );

    nco_round u_rnd (
        .clk    (clk),
        .rst_n  (rst_n),
        .amp    (amp),
        .sample (sample_s)
    );

    assign sample_out = sample_s;
endmodule

// File: rtl/nco_core_checker.sv
module nco_core_checker
    import nco_pkg::*;
(
    input logic                            clk,
    input logic                            rst_n,
    input logic                            update,
    input logic                            ofs_en,
    input logic [NUM_FREQ-1:0][WORD_W-1:0] freq_stg,
    input logic [NUM_FREQ-1:0][WORD_W-1:0] freq_act,
    input ctrl_t                           ctrl_act,
    input logic [WORD_W-1:0]               tune,
    input logic [WORD_W-1:0]               phase
);
    AST_STAGE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !update |=> $stable(freq_act)); // R2

    AST_UPDATE_COPY: assert property (@(posedge clk) disable iff (!rst_n)
        update |=> freq_act == $past(freq_stg)); // R2

    AST_ACC_INTEG: assert property (@(posedge clk) disable iff (!rst_n)
        ctrl_act.fb_en |=> phase == WORD_W'($past(phase) + $past(tune))); // R6

    AST_ACC_RELOAD: assert property (@(posedge clk) disable iff (!rst_n)
        !ctrl_act.fb_en |=> phase == $past(tune)); // R5

    AST_OFS_GATE: assert property (@(posedge clk) disable iff (!rst_n)
        (!ofs_en && !ctrl_act.ser_en) |-> tune == freq_act[FREQ_CENTER]); // R3
endmodule

bind nco_tuned_core nco_core_checker u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .update   (update),
    .ofs_en   (ofs_en),
    .freq_stg (freq_stg),
    .freq_act (freq_act),
    .ctrl_act (ctrl_act),
    .tune     (tune),
    .phase    (phase)
);

// File: tb/sim_nco_tuned_core.sv
module sim_nco_tuned_core;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [3:0]  wr_addr = '0;
    logic [7:0]  wr_data = '0;
    logic        update = 1'b0;
    logic        ofs_en = 1'b0;
    logic [13:0] sample_out;

    always #5 clk = ~clk;

    nco_tuned_core u0 (
        .clk        (clk),
        .rst_n      (rst_n),
        .wr_en      (wr_en),
        .wr_addr    (wr_addr),
        .wr_data    (wr_data),
        .update     (update),
        .ofs_en     (ofs_en),
        .sample_out (sample_out)
    );

    int    n_checks = 0;
    int    n_fail = 0;
    string cur_req = "R10";

    // Behavioural reference state
    logic [31:0] m_stg [3];
    logic [31:0] m_act [3];
    logic [1:0]  m_cstg, m_cact;
    logic [31:0] m_acc;
    logic [31:0] m_hist [$];

    function automatic logic [13:0] ref_sample(logic [31:0] ph);
        int quad = int'(ph[31:30]);
        int i = int'(ph[29:20]);
        int j = (quad % 2 == 1) ? 1023 - i : i;
        real pi = 3.14159265358979323846;
        int q = $rtoi(32767.0 * $sin(pi / 2.0 * (real'(j) + 0.5) / 1024.0) + 0.5);
        int a = (quad >= 2) ? -q : q;
        int r = (a + 2) >>> 2;
        if (r > 8191) r = 8191;
        return r[13:0];
    endfunction

    task automatic check(string req, logic [13:0] got, logic [13:0] exp);
        n_checks++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s: got %0d expected %0d", req, $signed(got), $signed(exp));
        end
    endtask

    always @(posedge clk) begin
        if (!rst_n) begin
            for (int k = 0; k < 3; k++) begin
                m_stg[k] = '0;
                m_act[k] = '0;
            end
            m_cstg = 2'b10;
            m_cact = 2'b10;
            m_acc  = '0;
            m_hist = {32'h0};
        end else begin
            logic [31:0] t;
            int a;
            t = m_act[0];
            if (ofs_en) t = t + m_act[1];
            if (m_cact[0]) t = t + m_act[2];
            m_acc = (m_cact[1] ? m_acc : 32'h0) + t;
            if (update) begin
                for (int k = 0; k < 3; k++) m_act[k] = m_stg[k];
                m_cact = m_cstg;
            end
            if (wr_en) begin
                a = int'(wr_addr);
                if (a < 12) m_stg[a / 4][(a % 4) * 8 +: 8] = wr_data;
                else if (a == 12) m_cstg = wr_data[1:0];
            end
            m_hist.push_back(m_acc);
            if (m_hist.size() > 4) void'(m_hist.pop_front());
        end
    end

    // Per-cycle comparison against the model (R6, R7, R9 and the active phase)
    always @(negedge clk) begin
        if (rst_n && m_hist.size() == 4)
            check(cur_req, sample_out, ref_sample(m_hist[0]));
    end

    task automatic idle(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic wr_byte(logic [3:0] a, logic [7:0] d);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic wr_word(logic [3:0] base, logic [31:0] w);
        for (int b = 0; b < 4; b++) wr_byte(base + 4'(b), w[b*8 +: 8]);
    endtask

    task automatic pulse_update();
        update = 1'b1;
        @(negedge clk);
        update = 1'b0;
    endtask

    initial begin
        #(200000 * 10);
        n_fail++;
        n_checks++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    initial begin
        logic [13:0] held;
        repeat (3) @(negedge clk);
        check("R10 reset output", sample_out, 14'h0);
        rst_n = 1'b1;

        // Center only, integrating
        cur_req = "R6 center integrate";
        wr_word(4'd0, 32'h0123_4567);
        cur_req = "R2 staged not active";
        idle(4);
        check("R2 no update yet", sample_out, ref_sample(32'h0));
        pulse_update();
        cur_req = "R7 quadrant sweep";
        idle(60);

        // Offset gate
        cur_req = "R3 offset gate";
        wr_word(4'd4, 32'h0380_0000);
        pulse_update();
        for (int k = 0; k < 6; k++) begin
            ofs_en = ~ofs_en;
            idle(5);
        end
        ofs_en = 1'b0;

        // Serial path switched in and out
        cur_req = "R4 serial gate";
        wr_word(4'd8, 32'h0C40_0000);
        wr_byte(4'd12, 8'h03);
        pulse_update();
        idle(10);
        wr_byte(4'd12, 8'h02);
        pulse_update();
        idle(10);
        wr_byte(4'd12, 8'h03);
        pulse_update();
        idle(10);

        // Reload mode with fixed phases
        cur_req = "R5 reload";
        wr_word(4'd0, 32'h0000_0000);
        wr_byte(4'd12, 8'h00);
        pulse_update();
        idle(6);
        check("R7 index 0", sample_out, 14'd6);
        wr_word(4'd0, 32'h8000_0000);
        pulse_update();
        idle(6);
        check("R7 third quadrant start", sample_out, 14'h3FFA);
        wr_word(4'd0, 32'h0000_0000);
        pulse_update();
        idle(6);

        // Latency and saturation
        cur_req = "R9 latency";
        wr_word(4'd0, 32'h3FF0_0000);
        pulse_update();
        idle(3);
        check("R9 before third edge", sample_out, 14'd6);
        idle(1);
        check("R8 positive clamp", sample_out, 14'h1FFF);
        wr_word(4'd0, 32'hC000_0000);
        pulse_update();
        idle(6);
        check("R8 most negative", sample_out, 14'h2000);

        // Unused addresses
        cur_req = "R1 unused addresses";
        held = sample_out;
        wr_byte(4'd13, 8'hFF);
        wr_byte(4'd14, 8'hA5);
        wr_byte(4'd15, 8'h5A);
        pulse_update();
        idle(6);
        check("R1 unused addr no effect", sample_out, held);

        // Back-to-back tone changes
        cur_req = "R11 fsk";
        wr_byte(4'd12, 8'h02);
        pulse_update();
        for (int k = 0; k < 10; k++) begin
            wr_byte(4'd3, 8'(8'h10 + 8'(k * 23)));
            pulse_update();
        end
        idle(8);

        // Reset acts only at an edge
        @(negedge clk);
        held = sample_out;
        rst_n = 1'b0;
        #2;
        check("R10 no async reset", sample_out, held);
        @(posedge clk);
        #1;
        check("R10 reset clears output", sample_out, 14'h0);
        @(negedge clk);
        rst_n = 1'b1;
        cur_req = "R10 after reset";
        wr_word(4'd0, 32'h0200_0000);
        pulse_update();
        idle(20);

        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end
endmodule